// File: doc/BRIEF.md
# SDRAM Read Capture Aligner

This block sits beside an SDR SDRAM controller and listens to the command lines it drives to the memory. When a READ goes out, the block works out when the matching words will show up on the data lines, samples them on the right clocks, and hands them on as a stream of words. Each word comes with a valid strobe, a flag on the closing word of the burst, and a small tag that gives the read's order of issue.

The block learns the CAS latency and the burst length while running. It snoops the mode-field address lines whenever a LOAD MODE command is issued. Each issued READ or PRECHARGE places an event into a short shift pipeline. The event enters at a depth chosen by the latency in force at issue time, so it comes out of the pipeline on the clock where its data is due. A READ that follows closely therefore queues behind the earlier one rather than blocking it. The later burst cuts the earlier one short at the clock where the new data starts. A PRECHARGE ends a running burst one latency after it is issued.

While clock enable is low, the block ignores the edge completely. No command is taken, nothing advances and nothing is captured.

Top module: `sdram_rd_capture`

## Requirements
- R1: After a synchronous active-high reset, rd_valid, rd_last and mode_err are low, the tag counter is 0, and the active setting is CAS latency 3 with a burst of 4 beats.
- R2: The command is {cs_n, ras_n, cas_n, we_n}. 0101 is READ, 0010 is PRECHARGE and 0000 is LOAD MODE. Every other code (NOP 0111, ACTIVE 0011, WRITE 0100, AUTO REFRESH 0001, and any code with cs_n high) has no effect on output or tag.
- R3: For a READ in enabled cycle t with latency CL and burst BL, dq_in is captured in enabled cycles t+CL through t+CL+BL-1. Each captured word appears on rd_data with rd_valid high one clock later.
- R4: On LOAD MODE, addr_len (address bits 2:0) selects the burst length: 000=1, 001=2, 010=4, 011=8. addr_lat (address bits 6:4) selects CAS latency, and 2 and 3 are accepted.
- R5: A LOAD MODE carrying an illegal latency or length code changes neither setting. It sets mode_err, which stays high until reset.
- R6: rd_last is high only together with rd_valid, and only on the final beat of a burst that runs to completion.
- R7: Each READ takes a 3-bit tag, starting at 0 after reset and counting up by one per READ with wrap-around. Every word of that read carries the tag on rd_tag.
- R8: A READ issued while earlier reads are still pending is queued, not blocked. If its first beat falls due while an older burst is still running, the older burst ends there without rd_last.
- R9: A PRECHARGE in enabled cycle p suppresses every beat that would be captured in enabled cycle p+CL or later. Beats due before then are still delivered.
- R10: A cycle with cke low is not counted. Any command in it is ignored, nothing is captured, and rd_valid is low on the following clock.
- R11: Latency and length are fixed per read when it is issued. A later LOAD MODE does not move or resize reads already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Memory clock enable; low cycles are skipped |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr_lat | input | 3 | Address bits 6:4, latency field of a mode load |
| addr_len | input | 3 | Address bits 2:0, burst-length field of a mode load |
| dq_in | input | DATA_W | Data lines from the memory |
| rd_data | output | DATA_W | Captured word |
| rd_valid | output | 1 | rd_data holds a captured word |
| rd_last | output | 1 | Closing word of a completed burst |
| rd_tag | output | 3 | Issue-order tag of the read owning the word |
| mode_err | output | 1 | Sticky flag for a rejected mode load |

## Verification
Several events can land in the same cycle:
- the first beat of a new burst and a leftover beat of an older one;
- a stall cycle in the middle of a running burst;
- a PRECHARGE whose cut-off falls inside a burst.

The bench provokes each case directly. Cases include two reads of four beats issued two clocks apart, and single-beat reads back to back. Another case reads with latency 3, then loads latency 2 and reads again before the first read's data is due.

A reference model in the bench fills a per-cycle schedule. A later READ or PRECHARGE overwrites the entries from its own due cycle onward. Each captured word is then judged against that schedule for cycle, data, tag and last flag.

// File: rtl/sdcap_pkg.sv
package sdcap_pkg;

    // Field widths shared by every stage of the aligner.
    localparam int unsigned TAG_W = 3;
    localparam int unsigned LEN_W = 4;
    localparam int unsigned LAT_W = 3;

    // Command codes on {cs_n, ras_n, cas_n, we_n} that the aligner acts on.
    localparam logic [3:0] CMD_LOADMODE  = 4'b0000;
    localparam logic [3:0] CMD_PRECHARGE = 4'b0010;
    localparam logic [3:0] CMD_READ      = 4'b0101;

    // Power-up setting: latency 3, burst of 4.
    localparam logic [LAT_W-1:0] DEF_LAT = LAT_W'(3);
    localparam logic [LEN_W-1:0] DEF_LEN = LEN_W'(4);

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_START = 2'd1,
        EV_STOP  = 2'd2
    } ev_kind_e;

    typedef struct packed {
        ev_kind_e           kind;
        logic [TAG_W-1:0]   tag;
        logic [LEN_W-1:0]   len;
    } ev_t;

    localparam ev_t EV_EMPTY = '{kind: EV_NONE, tag: '0, len: '0};

    function automatic logic len_code_ok(input logic [2:0] code);
        return code[2] == 1'b0;
    endfunction

    function automatic logic [LEN_W-1:0] len_from_code(input logic [2:0] code);
        return LEN_W'(1) << code[1:0];
    endfunction

    function automatic logic lat_code_ok(input logic [2:0] code);
        return (code == 3'd2) || (code == 3'd3);
    endfunction

endpackage

// File: rtl/sdcap_mode.sv
module sdcap_mode
    import sdcap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [2:0]       lat_code,
    input  logic [2:0]       len_code,
    output logic [LAT_W-1:0] cas_lat,
    output logic [LEN_W-1:0] burst_len,
    output logic             mode_err
);

    logic accept;
    assign accept = lat_code_ok(lat_code) && len_code_ok(len_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            cas_lat   <= DEF_LAT;
            burst_len <= DEF_LEN;
            mode_err  <= 1'b0;
        end else if (load) begin
            if (accept) begin
                cas_lat   <= LAT_W'(lat_code);
                burst_len <= len_from_code(len_code);
            end else begin
                mode_err  <= 1'b1;
            end
        end
    end

    // R4: the held latency is always one of the accepted values
    p_lat_legal_r4: assert property (@(posedge clk) disable iff (rst)
        (cas_lat == LAT_W'(2)) || (cas_lat == LAT_W'(3)));

    // R5: error flag is sticky
    p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        mode_err |=> mode_err);

    // R5: a rejected load leaves both settings untouched
    p_reject_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        (load && !accept) |=> ($stable(cas_lat) && $stable(burst_len) && mode_err));

endmodule

// File: rtl/sdcap_pipe.sv
module sdcap_pipe
    import sdcap_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             push,
    input  ev_t              push_ev,
    input  logic [LAT_W-1:0] push_lat,
    output ev_t              due
);

    localparam int unsigned IDX_W = $clog2(DEPTH + 1);

    ev_t stg [DEPTH];
    ev_t nxt [DEPTH];
    logic [IDX_W-1:0] ins;

    // An event entering at DEPTH-lat reaches the last stage lat enabled cycles after issue.
    assign ins = IDX_W'(DEPTH) - IDX_W'(push_lat);

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign nxt[i] = (push && ins == IDX_W'(i)) ? push_ev : EV_EMPTY;
        end else begin : g_body
            assign nxt[i] = (push && ins == IDX_W'(i)) ? push_ev : stg[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '{default: EV_EMPTY};
        end else if (adv) begin
            stg <= nxt;
        end
    end

    assign due = stg[DEPTH-1];

    // R3: the requested latency fits inside the pipeline
    p_lat_fits_r3: assert property (@(posedge clk) disable iff (rst)
        push |-> (push_lat >= LAT_W'(1)) && (32'(push_lat) <= DEPTH));

    // R10: a stalled cycle leaves the due event in place
    p_stall_freeze_r10: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(due));

endmodule

// File: rtl/sdcap_beat.sv
module sdcap_beat
    import sdcap_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  ev_t               due,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_last,
    output logic [TAG_W-1:0]  rd_tag
);

    logic [LEN_W-1:0] left_q;
    logic [TAG_W-1:0] tag_q;
    logic [LEN_W-1:0] left_now;
    logic [TAG_W-1:0] tag_now;
    logic             beat;

    // A starting burst overrides whatever is still running; a stop clears it.
    always_comb begin
        left_now = left_q;
        tag_now  = tag_q;
        unique case (due.kind)
            EV_START: begin
                left_now = due.len;
                tag_now  = due.tag;
            end
            EV_STOP:  left_now = '0;
            default:  ;
        endcase
    end

    assign beat = (left_now != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q   <= '0;
            tag_q    <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
            rd_tag   <= '0;
        end else if (adv) begin
            left_q   <= beat ? left_now - LEN_W'(1) : '0;
            tag_q    <= tag_now;
            rd_valid <= beat;
            rd_last  <= beat && (left_now == LEN_W'(1));
            rd_tag   <= tag_now;
            if (beat) begin
                rd_data <= dq_in;
            end
        end else begin
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
        end
    end

    // R6: closing flag only rides on a valid word
    p_last_valid_r6: assert property (@(posedge clk) disable iff (rst)
        rd_last |-> rd_valid);

    // R10: no word follows a stalled cycle
    p_quiet_stall_r10: assert property (@(posedge clk) disable iff (rst)
        !adv |=> !rd_valid);

    // R3: a burst start that falls due yields a word on the next clock
    p_start_emits_r3: assert property (@(posedge clk) disable iff (rst)
        (adv && due.kind == EV_START) |=> rd_valid);

    // R9: a stop that falls due yields no word
    p_stop_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (adv && due.kind == EV_STOP) |=> !rd_valid);

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture
    import sdcap_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [2:0]        addr_lat,
    input  logic [2:0]        addr_len,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_last,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              mode_err
);

    logic [3:0]       cmd;
    logic             is_read;
    logic             is_pre;
    logic             is_load;
    logic [LAT_W-1:0] cas_lat;
    logic [LEN_W-1:0] burst_len;
    logic [TAG_W-1:0] issue_tag;
    ev_t              push_ev;
    ev_t              due;

    assign cmd     = {cs_n, ras_n, cas_n, we_n};
    assign is_read = cke && (cmd == CMD_READ);
    assign is_pre  = cke && (cmd == CMD_PRECHARGE);
    assign is_load = cke && (cmd == CMD_LOADMODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            issue_tag <= '0;
        end else if (is_read) begin
            issue_tag <= issue_tag + TAG_W'(1);
        end
    end

    assign push_ev = is_read ? '{kind: EV_START, tag: issue_tag, len: burst_len}
                             : '{kind: EV_STOP,  tag: '0,        len: '0};

    sdcap_mode u_mode (
        .clk       (clk),
        .rst       (rst),
        .load      (is_load),
        .lat_code  (addr_lat),
        .len_code  (addr_len),
        .cas_lat   (cas_lat),
        .burst_len (burst_len),
        .mode_err  (mode_err)
    );

    sdcap_pipe #(.DEPTH(DEPTH)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .adv      (cke),
        .push     (is_read || is_pre),
        .push_ev  (push_ev),
        .push_lat (cas_lat),
        .due      (due)
    );

    sdcap_beat #(.DATA_W(DATA_W)) u_beat (
        .clk      (clk),
        .rst      (rst),
        .adv      (cke),
        .due      (due),
        .dq_in    (dq_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .rd_last  (rd_last),
        .rd_tag   (rd_tag)
    );

    // R7: each accepted READ advances the issue tag by one
    p_tag_step_r7: assert property (@(posedge clk) disable iff (rst)
        is_read |=> (issue_tag == $past(issue_tag) + TAG_W'(1)));

    // R2: commands other than READ leave the issue tag alone
    p_tag_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !is_read |=> $stable(issue_tag));

endmodule

// File: tb/sdram_rd_capture_test.sv
module sdram_rd_capture_test;

    localparam int CLK_PERIOD = 10;
    localparam int SLOTS      = 2048;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1;
    logic [3:0]  cmd = 4'b0111;
    logic [2:0]  a_lat = 3'd0;
    logic [2:0]  a_len = 3'd0;
    logic [15:0] dq = 16'h0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        rd_last;
    logic [2:0]  rd_tag;
    logic        mode_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_rd_capture uut (
        .clk      (clk),
        .rst      (rst),
        .cke      (cke),
        .cs_n     (cmd[3]),
        .ras_n    (cmd[2]),
        .cas_n    (cmd[1]),
        .we_n     (cmd[0]),
        .addr_lat (a_lat),
        .addr_len (a_len),
        .dq_in    (dq),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .rd_last  (rd_last),
        .rd_tag   (rd_tag),
        .mode_err (mode_err)
    );

    typedef struct {
        int          idx;
        logic [15:0] data;
        logic [2:0]  tag;
        logic        last;
        string       req;
    } exp_t;

    exp_t  q[$];
    bit    s_v    [SLOTS];
    bit    s_last [SLOTS];
    logic [2:0] s_tag [SLOTS];
    string s_req  [SLOTS];

    int    act      = 0;
    bit    prev_act = 1'b0;
    int    prev_idx = 0;
    int    cl_m     = 3;
    int    bl_m     = 4;
    bit    err_m    = 1'b0;
    logic [2:0] tag_m = 3'd0;
    string cur_req  = "R1";
    int    n_chk    = 0;
    int    n_bad    = 0;
    bit    done     = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] want);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, got, want, $time);
        end
    endtask

    task automatic clear_from(input int from);
        for (int i = from; i < from + 12 && i < SLOTS; i++) s_v[i] = 1'b0;
    endtask

    task automatic monitor();
        exp_t e;
        bit   due;
        chk(mode_err == err_m, "R5", "mode_err", 32'(mode_err), 32'(err_m));
        if (prev_act) begin
            due = (q.size() > 0) && (q[0].idx == prev_idx);
            if (due) begin
                e = q.pop_front();
                chk(rd_valid == 1'b1, e.req, "rd_valid", 32'(rd_valid), 32'd1);
                if (rd_valid) begin
                    chk(rd_data == e.data, e.req, "rd_data", 32'(rd_data), 32'(e.data));
                    chk(rd_tag == e.tag, e.req, "rd_tag", 32'(rd_tag), 32'(e.tag));
                    chk(rd_last == e.last, "R6", "rd_last", 32'(rd_last), 32'(e.last));
                end
            end else begin
                chk(rd_valid == 1'b0, cur_req, "stray rd_valid", 32'(rd_valid), 32'd0);
            end
        end else begin
            chk(rd_valid == 1'b0, "R10", "rd_valid after stall", 32'(rd_valid), 32'd0);
        end
    endtask

    task automatic model(input logic [3:0] c, input logic [2:0] lt, input logic [2:0] ln);
        if (c == 4'b0101) begin
            clear_from(act + cl_m);
            for (int k = 0; k < bl_m; k++) begin
                s_v[act + cl_m + k]    = 1'b1;
                s_tag[act + cl_m + k]  = tag_m;
                s_last[act + cl_m + k] = (k == bl_m - 1);
                s_req[act + cl_m + k]  = cur_req;
            end
            tag_m = tag_m + 3'd1;
        end else if (c == 4'b0010) begin
            clear_from(act + cl_m);
        end else if (c == 4'b0000) begin
            if ((lt == 3'd2 || lt == 3'd3) && ln <= 3'd3) begin
                cl_m = int'(lt);
                bl_m = 1 << ln;
            end else begin
                err_m = 1'b1;
            end
        end
    endtask

    task automatic step(input logic [3:0] c, input logic [2:0] lt,
                        input logic [2:0] ln, input bit k);
        exp_t e;
        @(negedge clk);
        monitor();
        cmd = c; a_lat = lt; a_len = ln; cke = k;
        if (k) begin
            dq = 16'hC000 | 16'(act[11:0]);
            model(c, lt, ln);
            if (s_v[act]) begin
                e.idx = act; e.data = dq; e.tag = s_tag[act];
                e.last = s_last[act]; e.req = s_req[act];
                q.push_back(e);
            end
            prev_act = 1'b1;
            prev_idx = act;
            act++;
        end else begin
            dq = 16'hFFFF;
            prev_act = 1'b0;
        end
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) step(4'b0111, 3'd0, 3'd0, 1'b1);
    endtask
    task automatic rd();  step(4'b0101, 3'd0, 3'd0, 1'b1); endtask
    task automatic pre(); step(4'b0010, 3'd0, 3'd0, 1'b1); endtask
    task automatic lmr(input logic [2:0] lt, input logic [2:0] ln);
        step(4'b0000, lt, ln, 1'b1);
    endtask

    initial begin
        for (int i = 0; i < SLOTS; i++) s_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(rd_valid == 1'b0, "R1", "rd_valid after reset", 32'(rd_valid), 32'd0);
        chk(rd_last == 1'b0, "R1", "rd_last after reset", 32'(rd_last), 32'd0);
        chk(mode_err == 1'b0, "R1", "mode_err after reset", 32'(mode_err), 32'd0);

        // R1 / R3: default latency 3, burst 4, first tag 0
        cur_req = "R1"; rd(); nop(8);

        // R2: non-read codes and a deselected READ do nothing
        cur_req = "R2";
        step(4'b0011, 3'd0, 3'd0, 1'b1);
        step(4'b0100, 3'd0, 3'd0, 1'b1);
        step(4'b0001, 3'd0, 3'd0, 1'b1);
        step(4'b1101, 3'd0, 3'd0, 1'b1);
        nop(4); rd(); nop(8);

        // R4: latency 2, burst 8; then latency 2, burst 2
        cur_req = "R4"; lmr(3'd2, 3'd3); rd(); nop(11);
        lmr(3'd2, 3'd1); rd(); nop(5);

        // R7 / R8: single-beat reads issued every cycle, tag wraps
        cur_req = "R7"; lmr(3'd3, 3'd0);
        for (int i = 0; i < 10; i++) rd();
        nop(6);

        // R8: second read interrupts the first after two beats
        cur_req = "R8"; lmr(3'd3, 3'd2); rd(); nop(1); rd(); nop(8);

        // R9: precharge cuts a burst of 8
        cur_req = "R9"; lmr(3'd2, 3'd3); rd(); nop(2); pre(); nop(12);

        // R10: stalls inside a burst; commands during stalls ignored
        cur_req = "R10"; rd(); nop(1);
        step(4'b0101, 3'd0, 3'd0, 1'b0);
        step(4'b0101, 3'd0, 3'd0, 1'b0);
        step(4'b0000, 3'd3, 3'd0, 1'b0);
        nop(12);

        // R5: illegal latency code 4, then illegal length code 7
        cur_req = "R5"; lmr(3'd4, 3'd2); nop(1); lmr(3'd3, 3'd7); rd(); nop(11);

        // R11: in-flight read keeps its latency across a mode load
        cur_req = "R11"; lmr(3'd3, 3'd2); rd(); lmr(3'd2, 3'd1); rd(); nop(10);

        chk(q.size() == 0, "R8", "undelivered beats", 32'(q.size()), 32'd0);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule